// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request on a small processor into one core reset line and records, in a set of sticky status flags, which source caused the most recent reset. The requests come from a brown-out detector, a second low-power brown-out detector, an external active-low reset pin, a watchdog expiry, a software reset instruction, stack overflow or underflow, and the end of a programming session. The analog detectors are not part of the block; their outputs arrive as digital levels.

Level inputs that change without regard to the clock (the two detector outputs and the pin) pass through two-flop synchronizers before use. The pin path also has a glitch filter. A power-up timer holds the core after a power-on, a brown-out or a programming exit. It runs whether or not the pin is held, so a pin kept low past the timer's expiry releases the core within a few cycles of going high. One-cycle requests from the watchdog, the CPU and the stack logic stretch the core reset for a short fixed interval. Software returns each flag to its idle value with a per-flag rearm strobe.

Top module: `reset_hub`

## Requirements
- R1: A high on `bor_det_i`, or a high on `lpbor_det_i` while `cfg_lpbor_en_i` is 1, holds `core_rst_o` high and drives `stat_o[1]` (brown-out flag, active low) to 0.
- R2: While `cfg_lpbor_en_i` is 0, `lpbor_det_i` has no effect on `core_rst_o` or on `stat_o[1]`.
- R3: The pin reset function is enabled when `cfg_lv_prog_i` is 1, whatever `cfg_pin_en_i` holds. When `cfg_lv_prog_i` is 0, it is enabled only if `cfg_pin_en_i` is 1.
- R4: With the pin function enabled, a synchronized low on `pin_lvl_i` lasting FILT_CYC or more cycles holds `core_rst_o` high. Shorter low pulses are ignored. With the function disabled, the pin has no effect.
- R5: A `wdt_expire_i` pulse raises `core_rst_o` at the next edge and holds it for HOLD_CYC+1 cycles. It also drives `stat_o[3]` (time-out, active low) to 0 and `stat_o[4]` (power-down, active low) to 1.
- R6: A `sw_reset_i` pulse resets the core as in R5 and drives `stat_o[2]` (reset-instruction flag, active low) to 0.
- R7: `stk_over_i` sets `stat_o[5]` and `stk_under_i` sets `stat_o[6]` (both active high) in every case. They reset the core only while `cfg_stk_rst_en_i` is 1.
- R8: A `prog_exit_i` pulse reloads `stat_o` with the power-on value 7'h1E and restarts the power-up timer, as a power-on does.
- R9: After power-on, a brown-out or a programming exit, `core_rst_o` stays high for PWRT_CYC cycles when `cfg_pwrt_en_i` is 1. When it is 0, no such delay is added.
- R10: `core_rst_o` falls only when the power-up timer has finished and the pin is not holding reset. The timer counts regardless of the pin. A pin released after the timer has expired frees the core within four cycles.
- R11: Flags are sticky. A 1 on `rearm_i[i]` returns `stat_o[i]` to its idle value (1 for bits 0 to 4, 0 for bits 5 and 6). A flag event in the same cycle wins over the strobe.
- R12: While `por_ni` is low, `core_rst_o` is 1 and `stat_o` is 7'h1E (bit 0, the power-on flag, active low, is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| bor_det_i | input | 1 | Brown-out detector output, high when supply is low |
| lpbor_det_i | input | 1 | Low-power brown-out detector output |
| pin_lvl_i | input | 1 | Level of the external reset pin (low requests reset) |
| wdt_expire_i | input | 1 | One-cycle watchdog expiry pulse |
| sw_reset_i | input | 1 | One-cycle software reset pulse |
| stk_over_i | input | 1 | One-cycle stack overflow pulse |
| stk_under_i | input | 1 | One-cycle stack underflow pulse |
| prog_exit_i | input | 1 | One-cycle pulse on leaving programming mode |
| cfg_lpbor_en_i | input | 1 | Enables the low-power brown-out source |
| cfg_pin_en_i | input | 1 | Pin reset enable, used when cfg_lv_prog_i is 0 |
| cfg_lv_prog_i | input | 1 | Low-voltage programming enable; forces the pin function on |
| cfg_stk_rst_en_i | input | 1 | Lets stack faults reset the core |
| cfg_pwrt_en_i | input | 1 | Enables the power-up timer |
| rearm_i | input | 7 | Per-flag strobes returning flags to idle values |
| core_rst_o | output | 1 | Core reset, active high |
| stat_o | output | 7 | Status flags: 0 power-on, 1 brown-out, 2 reset-instruction, 3 time-out, 4 power-down (all active low), 5 stack overflow, 6 stack underflow |

## Verification
The bench builds the block with PWRT_CYC = 24, FILT_CYC = 3 and HOLD_CYC = 2. A short timer makes the release edge after power-on, brown-out and programming exit reachable in a few dozen cycles. The bench checks it on both sides: held at 20 cycles, released by 26. A three-cycle filter lets a two-cycle low pin pulse sit just under the threshold while an eight-cycle low clears it. Holding the pin low for 60 cycles, well past the 24-cycle timer, shows the core freed within a handful of cycles of release.

// File: rtl/rhub_pkg.sv
package rhub_pkg;
   localparam int FLAG_W   = 7;
   localparam int F_POR    = 0;
   localparam int F_BOR    = 1;
   localparam int F_RI     = 2;
   localparam int F_TO     = 3;
   localparam int F_PD     = 4;
   localparam int F_OVF    = 5;
   localparam int F_UNF    = 6;
   // value of each flag when no event has been recorded
   localparam logic [FLAG_W-1:0] FLAG_IDLE = 7'b0011111;
   // value loaded on power-on or programming exit
   localparam logic [FLAG_W-1:0] FLAG_PON  = 7'b0011110;
endpackage

// File: rtl/rhub_sync.sv
module rhub_sync #(
   parameter int             W       = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("rhub_sync: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic stg1, stg2;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stg1 <= RST_VAL[b];
            stg2 <= RST_VAL[b];
         end else begin
            stg1 <= d_i[b];
            stg2 <= stg1;
         end
      end
      assign q_o[b] = stg2;
   end
endmodule

// File: rtl/rhub_pin_filter.sv
module rhub_pin_filter #(
   parameter int FILT_CYC = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic pin_i,
   output logic hold_o
);
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("rhub_pin_filter: FILT_CYC must be at least 1");
   end

   logic low_req;
   assign low_req = en_i & ~pin_i;

   if (FILT_CYC == 1) begin : g_direct
      logic hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) hold_q <= 1'b0;
         else         hold_q <= low_req;
      end
      assign hold_o = hold_q;
   end else begin : g_count
      localparam int CW = $clog2(FILT_CYC);
      localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
      logic [CW-1:0] cnt_q;
      logic          hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
         end else if (!low_req) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
         end else if (cnt_q != LAST) begin
            cnt_q  <= cnt_q + 1'b1;
         end else begin
            hold_q <= 1'b1;
         end
      end
      assign hold_o = hold_q;
   end
endmodule

// File: rtl/rhub_pwrup_timer.sv
module rhub_pwrup_timer #(
   parameter int PWRT_CYC = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic restart_i,
   output logic done_o
);
   if (PWRT_CYC < 1) begin : g_bad_len
      $error("rhub_pwrup_timer: PWRT_CYC must be at least 1");
   end

   localparam int CW = $clog2(PWRT_CYC + 1);
   localparam logic [CW-1:0] FULL = CW'(PWRT_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (restart_i)       cnt_q <= '0;
      else if (cnt_q != FULL)   cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = ~en_i | (cnt_q == FULL);
endmodule

// File: rtl/rhub_flags.sv
module rhub_flags
   import rhub_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reload_i,
   input  logic [FLAG_W-1:0] evt_i,
   input  logic [FLAG_W-1:0] rearm_i,
   output logic [FLAG_W-1:0] flag_o
);
   for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)         q <= FLAG_PON[b];
         else if (reload_i)   q <= FLAG_PON[b];
         else if (evt_i[b])   q <= ~FLAG_IDLE[b];
         else if (rearm_i[b]) q <= FLAG_IDLE[b];
      end
      assign flag_o[b] = q;
   end
endmodule

// File: rtl/reset_hub.sv
module reset_hub
   import rhub_pkg::*;
#(
   parameter int FILT_CYC = 4,
   parameter int PWRT_CYC = 64,
   parameter int HOLD_CYC = 3
) (
   input  logic              clk_i,
   input  logic              por_ni,
   input  logic              bor_det_i,
   input  logic              lpbor_det_i,
   input  logic              pin_lvl_i,
   input  logic              wdt_expire_i,
   input  logic              sw_reset_i,
   input  logic              stk_over_i,
   input  logic              stk_under_i,
   input  logic              prog_exit_i,
   input  logic              cfg_lpbor_en_i,
   input  logic              cfg_pin_en_i,
   input  logic              cfg_lv_prog_i,
   input  logic              cfg_stk_rst_en_i,
   input  logic              cfg_pwrt_en_i,
   input  logic [FLAG_W-1:0] rearm_i,
   output logic              core_rst_o,
   output logic [FLAG_W-1:0] stat_o
);
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("reset_hub: HOLD_CYC must be at least 1");
   end

   localparam int NSYNC = 3;
   localparam int HW    = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);

   logic [NSYNC-1:0] async_in, sync_out;
   logic bor_s, lpbor_s, pin_s;
   logic bor_act, pin_en, pin_hold, pt_done, pulse_trig;
   logic [HW-1:0] hold_q;
   logic core_q;
   logic [FLAG_W-1:0] evt, rearm_eff;

   assign async_in = {pin_lvl_i, lpbor_det_i, bor_det_i};

   rhub_sync #(.W(NSYNC), .RST_VAL(3'b100)) u_sync (
      .clk_i (clk_i),
      .rst_ni(por_ni),
      .d_i   (async_in),
      .q_o   (sync_out)
   );
   assign bor_s   = sync_out[0];
   assign lpbor_s = sync_out[1];
   assign pin_s   = sync_out[2];

   assign bor_act = bor_s | (lpbor_s & cfg_lpbor_en_i);
   assign pin_en  = cfg_lv_prog_i | cfg_pin_en_i;

   rhub_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(por_ni),
      .en_i  (pin_en),
      .pin_i (pin_s),
      .hold_o(pin_hold)
   );

   rhub_pwrup_timer #(.PWRT_CYC(PWRT_CYC)) u_pwrt (
      .clk_i    (clk_i),
      .rst_ni   (por_ni),
      .en_i     (cfg_pwrt_en_i),
      .restart_i(bor_act | prog_exit_i),
      .done_o   (pt_done)
   );

   assign pulse_trig = wdt_expire_i | sw_reset_i |
                       (cfg_stk_rst_en_i & (stk_over_i | stk_under_i));

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)              hold_q <= '0;
      else if (pulse_trig)      hold_q <= HOLD_LOAD;
      else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) core_q <= 1'b1;
      else         core_q <= bor_act | prog_exit_i | pin_hold | ~pt_done |
                             pulse_trig | (hold_q != '0);
   end
   assign core_rst_o = core_q;

   always_comb begin
      evt        = '0;
      evt[F_BOR] = bor_act;
      evt[F_RI]  = sw_reset_i;
      evt[F_TO]  = wdt_expire_i;
      evt[F_OVF] = stk_over_i;
      evt[F_UNF] = stk_under_i;
      rearm_eff        = rearm_i;
      rearm_eff[F_PD]  = rearm_i[F_PD] | wdt_expire_i;
   end

   rhub_flags u_flags (
      .clk_i   (clk_i),
      .rst_ni  (por_ni),
      .reload_i(prog_exit_i),
      .evt_i   (evt),
      .rearm_i (rearm_eff),
      .flag_o  (stat_o)
   );
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk (
   input logic       clk_i,
   input logic       por_ni,
   input logic       bor_act,
   input logic       pin_hold,
   input logic       pt_done,
   input logic       core_rst_o,
   input logic       wdt_expire_i,
   input logic       sw_reset_i,
   input logic       stk_over_i,
   input logic       prog_exit_i,
   input logic [6:0] stat_o
);
   AST_BOR_HOLDS_CORE: assert property (@(posedge clk_i) disable iff (!por_ni)
      bor_act |=> core_rst_o); // R1
   AST_PIN_HOLDS_CORE: assert property (@(posedge clk_i) disable iff (!por_ni)
      pin_hold |=> core_rst_o); // R4
   AST_TIMER_HOLDS_CORE: assert property (@(posedge clk_i) disable iff (!por_ni)
      !pt_done |=> core_rst_o); // R9
   AST_RELEASE_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!por_ni)
      $fell(core_rst_o) |-> ($past(pt_done) && !$past(pin_hold))); // R10
   AST_WDT_FLAGS: assert property (@(posedge clk_i) disable iff (!por_ni)
      (wdt_expire_i && !prog_exit_i) |=> (!stat_o[3] && stat_o[4])); // R5
   AST_SW_FLAG: assert property (@(posedge clk_i) disable iff (!por_ni)
      (sw_reset_i && !prog_exit_i) |=> !stat_o[2]); // R6
   AST_STK_FLAG: assert property (@(posedge clk_i) disable iff (!por_ni)
      (stk_over_i && !prog_exit_i) |=> stat_o[5]); // R7
   AST_PROG_RELOAD: assert property (@(posedge clk_i) disable iff (!por_ni)
      prog_exit_i |=> (stat_o == 7'h1E && core_rst_o)); // R8
endmodule

bind reset_hub reset_hub_chk u_chk (
   .clk_i       (clk_i),
   .por_ni      (por_ni),
   .bor_act     (bor_act),
   .pin_hold    (pin_hold),
   .pt_done     (pt_done),
   .core_rst_o  (core_rst_o),
   .wdt_expire_i(wdt_expire_i),
   .sw_reset_i  (sw_reset_i),
   .stk_over_i  (stk_over_i),
   .prog_exit_i (prog_exit_i),
   .stat_o      (stat_o)
);

// File: tb/reset_hub_bench.sv
module reset_hub_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PWRT = 24;
   localparam int FILT = 3;
   localparam int HOLD = 2;
   localparam int WD_LIMIT = 200000;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic bor_det = 0, lpbor_det = 0, pin_lvl = 1;
   logic wdt = 0, swr = 0, ovf = 0, unf = 0, pexit = 0;
   logic c_lpbor = 0, c_pin = 0, c_lv = 0, c_stk = 0, c_pwrt = 1;
   logic [6:0] rearm = '0;
   logic core_rst;
   logic [6:0] stat;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reset_hub #(.FILT_CYC(FILT), .PWRT_CYC(PWRT), .HOLD_CYC(HOLD)) u_reset_hub (
      .clk_i(clk), .por_ni(por_n), .bor_det_i(bor_det), .lpbor_det_i(lpbor_det),
      .pin_lvl_i(pin_lvl), .wdt_expire_i(wdt), .sw_reset_i(swr),
      .stk_over_i(ovf), .stk_under_i(unf), .prog_exit_i(pexit),
      .cfg_lpbor_en_i(c_lpbor), .cfg_pin_en_i(c_pin), .cfg_lv_prog_i(c_lv),
      .cfg_stk_rst_en_i(c_stk), .cfg_pwrt_en_i(c_pwrt), .rearm_i(rearm),
      .core_rst_o(core_rst), .stat_o(stat));

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic power_up();
      por_n = 1'b0;
      tick(2);
      por_n = 1'b1;
      tick(PWRT + 6);
   endtask

   task automatic t_por();
      por_n = 1'b0;
      tick(2);
      chk("R12 core in reset", 32'(core_rst), 1);
      chk("R12 power-on flags", 32'(stat), 32'h1E);
      por_n = 1'b1;
      tick(20);
      chk("R9 timer still holding", 32'(core_rst), 1);
      tick(6);
      chk("R9 released after timer", 32'(core_rst), 0);
   endtask

   task automatic t_pwrt_off();
      c_pwrt = 1'b0;
      por_n = 1'b0;
      tick(2);
      por_n = 1'b1;
      tick(3);
      chk("R9 no delay when timer disabled", 32'(core_rst), 0);
      c_pwrt = 1'b1;
      power_up();
   endtask

   task automatic t_bor();
      bor_det = 1'b1;
      tick(5);
      chk("R1 brown-out holds core", 32'(core_rst), 1);
      chk("R1 brown-out flag", 32'(stat[1]), 0);
      bor_det = 1'b0;
      tick(10);
      chk("R9 timer restarted by brown-out", 32'(core_rst), 1);
      tick(30);
      chk("R9 release after brown-out", 32'(core_rst), 0);
      chk("R11 brown-out flag sticky", 32'(stat[1]), 0);
      rearm[1] = 1'b1;
      tick(1);
      rearm[1] = 1'b0;
      chk("R11 rearm brown-out flag", 32'(stat[1]), 1);
   endtask

   task automatic t_lpbor();
      c_lpbor = 1'b0;
      lpbor_det = 1'b1;
      tick(6);
      chk("R2 disabled low-power detector no reset", 32'(core_rst), 0);
      chk("R2 disabled low-power detector no flag", 32'(stat[1]), 1);
      lpbor_det = 1'b0;
      tick(2);
      c_lpbor = 1'b1;
      lpbor_det = 1'b1;
      tick(5);
      chk("R1 low-power detector holds core", 32'(core_rst), 1);
      chk("R1 low-power detector sets shared flag", 32'(stat[1]), 0);
      lpbor_det = 1'b0;
      tick(PWRT + 8);
      chk("R1 release after low-power brown-out", 32'(core_rst), 0);
      rearm[1] = 1'b1;
      tick(1);
      rearm[1] = 1'b0;
      c_lpbor = 1'b0;
   endtask

   task automatic t_pin();
      bit seen;
      c_lv = 0; c_pin = 0;
      pin_lvl = 1'b0;
      tick(8);
      chk("R3 R4 pin disabled has no effect", 32'(core_rst), 0);
      pin_lvl = 1'b1;
      tick(4);
      c_lv = 1; c_pin = 0;
      pin_lvl = 1'b0;
      tick(2);
      pin_lvl = 1'b1;
      seen = 0;
      for (int i = 0; i < 8; i++) begin
         tick(1);
         if (core_rst) seen = 1;
      end
      chk("R4 short low pulse filtered", 32'(seen), 0);
      pin_lvl = 1'b0;
      tick(8);
      chk("R3 low-voltage bit enables pin", 32'(core_rst), 1);
      pin_lvl = 1'b1;
      tick(6);
      chk("R10 pin release frees core", 32'(core_rst), 0);
      c_lv = 0; c_pin = 1;
      pin_lvl = 1'b0;
      tick(8);
      chk("R3 pin-enable bit enables pin", 32'(core_rst), 1);
      pin_lvl = 1'b1;
      tick(6);
      chk("R4 release after enabled pin", 32'(core_rst), 0);
   endtask

   task automatic t_pin_independent();
      c_lv = 0; c_pin = 1;
      pin_lvl = 1'b0;
      por_n = 1'b0;
      tick(2);
      por_n = 1'b1;
      tick(60);
      chk("R10 pin keeps core after timer", 32'(core_rst), 1);
      pin_lvl = 1'b1;
      tick(5);
      chk("R10 immediate start after expired timer", 32'(core_rst), 0);
      c_pin = 0;
   endtask

   task automatic t_wdt();
      wdt = 1'b1;
      tick(1);
      wdt = 1'b0;
      chk("R5 watchdog raises core reset", 32'(core_rst), 1);
      chk("R5 time-out flag low", 32'(stat[3]), 0);
      chk("R5 power-down flag high", 32'(stat[4]), 1);
      tick(2);
      chk("R5 hold lasts HOLD+1 cycles", 32'(core_rst), 1);
      tick(1);
      chk("R5 hold ends", 32'(core_rst), 0);
   endtask

   task automatic t_sw();
      chk("R6 flag idle before", 32'(stat[2]), 1);
      swr = 1'b1;
      tick(1);
      swr = 1'b0;
      chk("R6 software reset raises core reset", 32'(core_rst), 1);
      chk("R6 reset-instruction flag low", 32'(stat[2]), 0);
      tick(4);
      chk("R6 hold ends", 32'(core_rst), 0);
   endtask

   task automatic t_stk();
      bit seen;
      c_stk = 1'b0;
      ovf = 1'b1;
      tick(1);
      ovf = 1'b0;
      seen = core_rst;
      for (int i = 0; i < 4; i++) begin
         tick(1);
         if (core_rst) seen = 1;
      end
      chk("R7 overflow without enable no reset", 32'(seen), 0);
      chk("R7 overflow flag set", 32'(stat[5]), 1);
      c_stk = 1'b1;
      unf = 1'b1;
      tick(1);
      unf = 1'b0;
      chk("R7 underflow with enable resets", 32'(core_rst), 1);
      chk("R7 underflow flag set", 32'(stat[6]), 1);
      tick(4);
      c_stk = 1'b0;
   endtask

   task automatic t_rearm();
      ovf = 1'b1;
      rearm[5] = 1'b1;
      tick(1);
      ovf = 1'b0;
      chk("R11 event wins over rearm", 32'(stat[5]), 1);
      tick(1);
      rearm[5] = 1'b0;
      chk("R11 rearm overflow flag", 32'(stat[5]), 0);
      rearm[3] = 1'b1;
      rearm[6] = 1'b1;
      tick(1);
      rearm = '0;
      chk("R11 rearm time-out and underflow", 32'({stat[6], stat[3]}), 32'b01);
   endtask

   task automatic t_prog();
      pexit = 1'b1;
      tick(1);
      pexit = 1'b0;
      chk("R8 programming exit reloads flags", 32'(stat), 32'h1E);
      chk("R8 programming exit resets core", 32'(core_rst), 1);
      tick(9);
      chk("R9 timer restarted by programming exit", 32'(core_rst), 1);
      tick(20);
      chk("R9 release after programming exit", 32'(core_rst), 0);
   endtask

   initial begin : watchdog
      for (int c = 0; c < WD_LIMIT; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      tick(1);
      t_por();
      t_pwrt_off();
      t_bor();
      t_lpbor();
      t_pin();
      t_pin_independent();
      t_wdt();
      t_sw();
      t_stk();
      t_rearm();
      t_prog();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule